// File: doc/BRIEF.md
# Supply Phase and Standby Mode Sequencer

This block is the supervisory state machine of an off-line switching supply controller. It reads digital flags from the supply-rail comparators and from the demagnetisation-current comparators, and from them decides the controller's phase. Those phases are charging the supply capacitor from the high-voltage start source, switching, and waiting with switching off while the supply rail discharges. When the rail is exhausted the cycle repeats, so a sustained overload turns into a low-duty hiccup.

The same hiccup is reused as a low-power burst standby. The switching logic reports how each on-time ended: by the PWM comparison or by the over-current comparator. The latest report is held in a one-bit memory. On entry to the waiting phase that memory is moved into a mode latch. While the latch reads standby, a current-sense bias source is enabled during start-up and switching, which lowers the peak-current limit. A separate demag-current-low flag returns the block to normal mode at once. Over-voltage on the supply or on the demag input latches switching off until the next start-up, and over-temperature blocks switching for as long as it is present.

All comparator flags are synchronised with two flops and must hold a new value for `STABLE_CYCLES` clocks before they count.

Top module: `supply_seq`

## Requirements
- R1: After reset the block is in the start-up phase in normal mode: hvSourceEn=1, switchEn=0, standbySourceEn=0, standbyMode=0.
- R2: In start-up, a filtered vccAboveStart=1 moves the block to switching: hvSourceEn=0 and switchEn=1, never both high together.
- R3: In switching, a filtered vccAboveUvlo1=0 moves the block to the wait phase: hvSourceEn=0, switchEn=0, standbySourceEn=0. The wait phase is entered only from switching.
- R4: In the wait phase, a filtered vccAboveUvlo2=0 moves the block back to start-up (hvSourceEn=1). Switching is entered only from start-up.
- R5: A cycleDone pulse during switching stores cycleNoOc (1 = on-time ended by PWM, 0 = ended by over-current) as the last-cycle flag. On entry to the wait phase standbyMode takes that flag's value, and it keeps it through the following start-up. On entry to start-up with the flag at 0, standbyMode is cleared.
- R6: standbySourceEn=1 exactly when standbyMode=1 and the phase is start-up or switching.
- R7: A filtered demagBelowRecover=1 clears standbyMode in any phase, without waiting for a phase change.
- R8: A filtered vccOverVolt=1 or demagAboveOvp=1 forces switchEn=0. The effect stays latched after the flag drops, until the next entry to start-up.
- R9: A filtered overTemp=1 forces switchEn=0 only while it is asserted.
- R10: A flag change held for fewer than STABLE_CYCLES clocks has no effect. A held change alters the phase, mode or protection latch exactly STABLE_CYCLES+3 clocks after the input edge, and gates switchEn for overTemp after STABLE_CYCLES+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vccAboveStart | input | 1 | Supply above start threshold (asynchronous) |
| vccAboveUvlo1 | input | 1 | Supply above switching-stop threshold (asynchronous) |
| vccAboveUvlo2 | input | 1 | Supply above restart threshold (asynchronous) |
| vccOverVolt | input | 1 | Supply over-voltage (asynchronous) |
| demagAboveOvp | input | 1 | Demag current above quick over-voltage level (asynchronous) |
| demagBelowRecover | input | 1 | Demag current below normal-mode recovery level (asynchronous) |
| overTemp | input | 1 | Die over-temperature (asynchronous) |
| cycleDone | input | 1 | One-clock pulse at the end of each on-time (synchronous) |
| cycleNoOc | input | 1 | End cause qualifying cycleDone: 1 PWM, 0 over-current |
| hvSourceEn | output | 1 | High-voltage start source enable |
| switchEn | output | 1 | Power switch driver enable |
| standbySourceEn | output | 1 | Current-sense bias source enable |
| standbyMode | output | 1 | 1 = pulsed standby mode, 0 = normal |

## Verification
A flag change passes two synchroniser flops and then STABLE_CYCLES debounce clocks. It reaches the phase register, the mode latch or the protection latch on clock STABLE_CYCLES+3, and reaches the thermal gate of switchEn on clock STABLE_CYCLES+2. The bench drives each change just after an edge and samples one time unit after the due edge. Where latency is the subject it also samples one edge earlier, to see the old value. The cycleDone capture lands on the next edge, and the bench lets it settle before moving the supply flags. The mode is swept over both end-cause values crossed with the presence or absence of a demag-low recovery. Both over-voltage sources are swept through a full latch-and-restart round.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

  typedef enum logic [1:0] {
    PH_START   = 2'd0,
    PH_SWITCH  = 2'd1,
    PH_LATCHED = 2'd2
  } phase_e;

  localparam int FLAG_COUNT = 7;
  localparam int F_START    = 0;
  localparam int F_UVLO1    = 1;
  localparam int F_UVLO2    = 2;
  localparam int F_VCC_OV   = 3;
  localparam int F_DMG_OVP  = 4;
  localparam int F_DMG_LOW  = 5;
  localparam int F_OTEMP    = 6;

  typedef struct packed {
    logic enterLatched;
    logic enterStartup;
    logic inSwitch;
  } seq_strobe_t;

  typedef struct packed {
    logic startOk;
    logic uvlo1Ok;
    logic uvlo2Ok;
    logic thermalTrip;
    logic ovpLatched;
    logic standby;
  } seq_status_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import supply_seq_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FLAG_COUNT-1:0] rawFlags,
  input  logic                  cycleDone,
  input  logic                  cycleNoOc,
  input  seq_strobe_t           strb,
  output seq_status_t           status
);

  localparam int CNT_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [FLAG_COUNT-1:0] syncA;
  logic [FLAG_COUNT-1:0] syncB;
  logic [FLAG_COUNT-1:0] filt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= rawFlags;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
    if (STABLE_CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) filt[g] <= 1'b0;
        else       filt[g] <= syncB[g];
      end
    end else begin : g_debounce
      logic [CNT_W-1:0] holdCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdCnt <= '0;
          filt[g] <= 1'b0;
        end else if (syncB[g] != filt[g]) begin
          if (holdCnt == CNT_LAST) begin
            holdCnt <= '0;
            filt[g] <= syncB[g];
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end else begin
          holdCnt <= '0;
        end
      end
    end
  end

  logic lastNoOc;
  logic modeQ;
  logic ovpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lastNoOc <= 1'b0;
    else if (cycleDone && strb.inSwitch) lastNoOc <= cycleNoOc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 modeQ <= 1'b0;
    else if (filt[F_DMG_LOW])                  modeQ <= 1'b0;
    else if (strb.enterLatched)                modeQ <= lastNoOc;
    else if (strb.enterStartup && !lastNoOc)   modeQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 ovpQ <= 1'b0;
    else if (filt[F_VCC_OV] || filt[F_DMG_OVP]) ovpQ <= 1'b1;
    else if (strb.enterStartup)                ovpQ <= 1'b0;
  end

  always_comb begin
    status.startOk     = filt[F_START];
    status.uvlo1Ok     = filt[F_UVLO1];
    status.uvlo2Ok     = filt[F_UVLO2];
    status.thermalTrip = filt[F_OTEMP];
    status.ovpLatched  = ovpQ;
    status.standby     = modeQ;
  end

  // R5: standby is only entered from a stored PWM-ended cycle at wait entry
  p_mode_set_from_lw_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ) |-> $past(strb.enterLatched && lastNoOc));

  // R8: the protection latch is released only at start-up entry
  p_ovp_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovpQ) |-> $past(strb.enterStartup));

  // R7: a filtered recovery flag leaves the block in normal mode next cycle
  p_recover_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    filt[F_DMG_LOW] |=> !modeQ);

endmodule

// File: rtl/seq_control.sv
module seq_control
  import supply_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seq_status_t status,
  output seq_strobe_t strb,
  output logic        hvSourceEn,
  output logic        switchEn,
  output logic        standbySourceEn,
  output logic        standbyMode
);

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_START:   if (status.startOk)  phaseNext = PH_SWITCH;
      PH_SWITCH:  if (!status.uvlo1Ok) phaseNext = PH_LATCHED;
      PH_LATCHED: if (!status.uvlo2Ok) phaseNext = PH_START;
      default:                         phaseNext = PH_START;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_START;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.enterLatched = (phase == PH_SWITCH)  && (phaseNext == PH_LATCHED);
    strb.enterStartup = (phase == PH_LATCHED) && (phaseNext == PH_START);
    strb.inSwitch     = (phase == PH_SWITCH);
  end

  always_comb begin
    hvSourceEn      = (phase == PH_START);
    switchEn        = (phase == PH_SWITCH) && !status.ovpLatched && !status.thermalTrip;
    standbyMode     = status.standby;
    standbySourceEn = status.standby && (phase != PH_LATCHED);
  end

  // R2: start source and driver are never enabled together
  p_hv_sw_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hvSourceEn, switchEn}));

  // R4: switching is only entered from start-up
  p_switch_from_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SWITCH && $past(phase) != PH_SWITCH) |-> $past(phase) == PH_START);

  // R3: the wait phase is only entered from switching
  p_wait_from_switch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LATCHED && $past(phase) != PH_LATCHED) |-> $past(phase) == PH_SWITCH);

  // R6: the bias source is never on in normal mode
  p_bias_needs_standby_r6: assert property (@(posedge clk) disable iff (!rstN)
    standbySourceEn |-> standbyMode);

  // R8: a latched over-voltage keeps the driver off
  p_ovp_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    status.ovpLatched |-> !switchEn);

endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import supply_seq_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccAboveStart,
  input  logic vccAboveUvlo1,
  input  logic vccAboveUvlo2,
  input  logic vccOverVolt,
  input  logic demagAboveOvp,
  input  logic demagBelowRecover,
  input  logic overTemp,
  input  logic cycleDone,
  input  logic cycleNoOc,
  output logic hvSourceEn,
  output logic switchEn,
  output logic standbySourceEn,
  output logic standbyMode
);

  logic [FLAG_COUNT-1:0] rawFlags;
  seq_strobe_t           strb;
  seq_status_t           status;

  always_comb begin
    rawFlags            = '0;
    rawFlags[F_START]   = vccAboveStart;
    rawFlags[F_UVLO1]   = vccAboveUvlo1;
    rawFlags[F_UVLO2]   = vccAboveUvlo2;
    rawFlags[F_VCC_OV]  = vccOverVolt;
    rawFlags[F_DMG_OVP] = demagAboveOvp;
    rawFlags[F_DMG_LOW] = demagBelowRecover;
    rawFlags[F_OTEMP]   = overTemp;
  end

  seq_datapath #(.STABLE_CYCLES(STABLE_CYCLES)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .rawFlags  (rawFlags),
    .cycleDone (cycleDone),
    .cycleNoOc (cycleNoOc),
    .strb      (strb),
    .status    (status)
  );

  seq_control control_i (
    .clk             (clk),
    .rstN            (rstN),
    .status          (status),
    .strb            (strb),
    .hvSourceEn      (hvSourceEn),
    .switchEn        (switchEn),
    .standbySourceEn (standbySourceEn),
    .standbyMode     (standbyMode)
  );

endmodule

// File: tb/supply_seq_tb_top.sv
module supply_seq_tb_top;

  localparam int S   = 4;
  localparam int LAT = S + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccAboveStart = 0, vccAboveUvlo1 = 0, vccAboveUvlo2 = 0;
  logic vccOverVolt = 0, demagAboveOvp = 0, demagBelowRecover = 0, overTemp = 0;
  logic cycleDone = 0, cycleNoOc = 0;
  logic hvSourceEn, switchEn, standbySourceEn, standbyMode;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  supply_seq #(.STABLE_CYCLES(S)) dut_i (
    .clk(clk), .rstN(rstN),
    .vccAboveStart(vccAboveStart), .vccAboveUvlo1(vccAboveUvlo1),
    .vccAboveUvlo2(vccAboveUvlo2), .vccOverVolt(vccOverVolt),
    .demagAboveOvp(demagAboveOvp), .demagBelowRecover(demagBelowRecover),
    .overTemp(overTemp), .cycleDone(cycleDone), .cycleNoOc(cycleNoOc),
    .hvSourceEn(hvSourceEn), .switchEn(switchEn),
    .standbySourceEn(standbySourceEn), .standbyMode(standbyMode)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOuts(input string req, input logic hv, input logic sw,
                            input logic sb, input logic md);
    checks++;
    if ({hvSourceEn, switchEn, standbySourceEn, standbyMode} !== {hv, sw, sb, md}) begin
      fails++;
      $display("FAIL %s: hv/sw/sb/mode actual %b%b%b%b expected %b%b%b%b", req,
               hvSourceEn, switchEn, standbySourceEn, standbyMode, hv, sw, sb, md);
    end
  endtask

  // Supply rises through both lower thresholds, then the start threshold
  task automatic powerUp(input logic md);
    vccAboveUvlo2 = 1; vccAboveUvlo1 = 1;
    edges(LAT);
    expectOuts("R4", 1, 0, md, md);
    vccAboveStart = 1;
    edges(LAT);
    expectOuts("R2", 0, 1, md, md);
  endtask

  // Supply falls below start, then UVLO1 (wait phase), then UVLO2 (start-up)
  task automatic fallToWait(input logic md);
    vccAboveStart = 0;
    edges(LAT);
    vccAboveUvlo1 = 0;
    edges(LAT);
    expectOuts("R3", 0, 0, 0, md);
  endtask

  task automatic fallToStart(input logic md);
    vccAboveUvlo2 = 0;
    edges(LAT);
    expectOuts("R4", 1, 0, md, md);
  endtask

  task automatic endCycle(input logic noOc);
    cycleNoOc = noOc; cycleDone = 1;
    edges(1);
    cycleDone = 0;
    edges(1);
  endtask

  initial begin
    edges(3);
    rstN = 1;
    edges(1);
    expectOuts("R1", 1, 0, 0, 0);

    // R10: glitch of S-1 clocks on the start flag is ignored
    vccAboveUvlo2 = 1; vccAboveUvlo1 = 1;
    edges(LAT);
    vccAboveStart = 1;
    edges(S - 1);
    vccAboveStart = 0;
    edges(LAT + 2);
    expectOuts("R10", 1, 0, 0, 0);

    // R10: held change is due on edge S+3, not S+2
    vccAboveStart = 1;
    edges(LAT - 1);
    expectOuts("R10", 1, 0, 0, 0);
    edges(1);
    expectOuts("R10", 0, 1, 0, 0);

    // R5/R6/R7 sweep: end cause x recovery flag
    for (int lwVal = 0; lwVal < 2; lwVal++) begin
      for (int rec = 0; rec < 2; rec++) begin
        logic expMode;
        endCycle(!lwVal[0]);
        endCycle(lwVal[0]);
        expMode = lwVal[0];
        fallToWait(expMode);
        if (rec == 1) begin
          demagBelowRecover = 1;
          edges(LAT);
          expMode = 1'b0;
          expectOuts("R7", 0, 0, 0, expMode);
          demagBelowRecover = 0;
          edges(LAT);
        end
        fallToStart(expMode);
        powerUp(expMode);
        expectOuts("R6", 0, 1, expMode, expMode);
      end
    end

    // Return to normal mode for the protection checks
    endCycle(0);
    fallToWait(0);
    fallToStart(0);
    powerUp(0);

    // R9: thermal gating, due S+2 edges after the input change
    overTemp = 1;
    edges(S + 1);
    expectOuts("R9", 0, 1, 0, 0);
    edges(1);
    expectOuts("R9", 0, 0, 0, 0);
    overTemp = 0;
    edges(S + 2);
    expectOuts("R9", 0, 1, 0, 0);

    // R8: both over-voltage sources latch until the next start-up
    for (int src = 0; src < 2; src++) begin
      if (src == 0) vccOverVolt = 1; else demagAboveOvp = 1;
      edges(LAT);
      expectOuts("R8", 0, 0, 0, 0);
      vccOverVolt = 0; demagAboveOvp = 0;
      edges(LAT * 2);
      expectOuts("R8", 0, 0, 0, 0);
      fallToWait(0);
      fallToStart(0);
      powerUp(0);
      expectOuts("R8", 0, 1, 0, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule